// File: doc/BRIEF.md
# Partial-Word Byte-Store Aligner

This block turns a store-bytes request into one aligned word write for a big-endian memory. A request carries a byte address, a 32-bit register value and a direction. The low address bits decide which byte lanes of the containing word are written. In the head direction, the store covers the addressed byte and every byte after it up to the end of the word. In the tail direction, the store covers the first byte of the word and every byte up to, but not including, the addressed byte. In the tail direction, the bytes come from the most significant end of the register.

Each request produces exactly one write beat: the word-aligned address, a byte-enable mask, lane-placed data and a write strobe. A three-byte store is therefore a single write and cannot be split. A tail-direction request at an aligned address selects no bytes. In that case the write strobe stays low and a separate probe strobe rises instead, so that the downstream memory system can check write permission and mark the line dirty. Address translation, protection and cache handling belong to the blocks that consume these outputs.

Top module: `bytestore_align`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wr_valid`, `probe_valid` and `wr_be` are all zero.
- R2: Outputs are registered. The result of a request accepted at a clock edge appears after that edge. A cycle with `req_valid` low leaves both `wr_valid` and `probe_valid` low after the next edge.
- R3: Head direction (`req_mode` = 0) with byte offset k = `req_addr[1:0]` enables byte offsets k..3. Byte offset j maps to `wr_be` bit 3-j. Offsets 0, 1, 2 and 3 therefore give 1111, 0111, 0011 and 0001.
- R4: Tail direction (`req_mode` = 1) with byte offset k enables byte offsets 0..k-1. Offsets 3, 2 and 1 therefore give 1110, 1100 and 1000.
- R5: Tail direction at offset 0 gives `wr_be` = 0000, keeps `wr_valid` low and raises `probe_valid` for one cycle.
- R6: `wr_addr` equals the request address with bits 1:0 cleared.
- R7: Data is big-endian. Byte offset j occupies `wr_data` bits 31-8j down to 24-8j. Each enabled lane carries the register byte from the same bit positions. Disabled lanes are zero.
- R8: `wr_valid` and `probe_valid` are never high together. `wr_valid` high implies a nonzero `wr_be`, and `probe_valid` high implies `wr_be` = 0000.
- R9: Requests on consecutive cycles each produce their own complete, unmixed result on the cycle after they are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 1 | 0 = head direction, 1 = tail direction |
| req_addr | input | ADDR_W (32) | Byte address of the request |
| req_data | input | DATA_W (32) | Register value to store |
| wr_valid | output | 1 | Write beat present |
| wr_addr | output | ADDR_W (32) | Word-aligned write address |
| wr_be | output | DATA_W/8 (4) | Byte enables, bit 3 = byte offset 0 |
| wr_data | output | DATA_W (32) | Lane-placed write data |
| probe_valid | output | 1 | Permission probe with no bytes written |

## Verification
Two things can share a clock edge. The first is a new request being captured. The second is the previous request's result, which is still on the outputs at that edge, whether it is a write beat or a probe. The sweep provokes this by issuing every direction and offset back to back with no idle cycle, so a tail offset-0 probe is always followed or preceded by a real write. Each result is judged on the cycle after its own request against a mask and data computed per byte offset in the bench. A stale or mixed field from the neighbouring request would therefore show up as a mismatch.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
   typedef enum logic {
      BSA_HEAD = 1'b0,
      BSA_TAIL = 1'b1
   } bsa_mode_e;
endpackage

// File: rtl/bsa_lane_mask.sv
module bsa_lane_mask #(
   parameter int LANES = 4,
   parameter int OFF_W = 2
) (
   input  logic [OFF_W-1:0]  off,
   input  bsa_pkg::bsa_mode_e mode,
   output logic [LANES-1:0]  be
);
   logic [LANES-1:0] head_mask;

   // head: lanes from offset to end of word; bit LANES-1 is offset 0
   assign head_mask = {LANES{1'b1}} >> off;
   assign be        = (mode == bsa_pkg::BSA_TAIL) ? ~head_mask : head_mask;

   always_comb begin
      if (mode == bsa_pkg::BSA_HEAD) begin
         assert_head_last_lane_R3: assert (be[0]);
      end else begin
         assert_tail_no_last_lane_R4: assert (!be[0]);
      end
   end
endmodule

// File: rtl/bsa_lane_gate.sv
module bsa_lane_gate #(
   parameter int LANES       = 4,
   parameter bit ZERO_UNUSED = 1'b1
) (
   input  logic [8*LANES-1:0] din,
   input  logic [LANES-1:0]   be,
   output logic [8*LANES-1:0] dout
);
   generate
      if (ZERO_UNUSED) begin : g_zero
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign dout[8*i +: 8] = be[i] ? din[8*i +: 8] : 8'h00;
         end
      end else begin : g_pass
         logic unused_be;
         assign unused_be = ^be;
         assign dout      = din;
      end
   endgenerate
endmodule

// File: rtl/bsa_out_stage.sv
module bsa_out_stage #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              go_write,
   input  logic              go_probe,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [LANES-1:0]  be_d,
   input  logic [DATA_W-1:0] data_d,
   output logic              wr_valid,
   output logic              probe_valid,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LANES-1:0]  be_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_valid    <= 1'b0;
         probe_valid <= 1'b0;
         addr_q      <= '0;
         be_q        <= '0;
         data_q      <= '0;
      end else begin
         wr_valid    <= load & go_write;
         probe_valid <= load & go_probe;
         if (load) begin
            addr_q <= addr_d;
            be_q   <= be_d;
            data_q <= data_d;
         end
      end
   end
endmodule

// File: rtl/bytestore_align.sv
module bytestore_align #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter bit ZERO_UNUSED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_mode,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_data,
   output logic                wr_valid,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W/8-1:0] wr_be,
   output logic [DATA_W-1:0]   wr_data,
   output logic                probe_valid
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   generate
      if ((DATA_W % 8) != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
         $error("bytestore_align: DATA_W must be 8 times a power of two, at least 16");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("bytestore_align: ADDR_W too small for lane offset");
      end
   endgenerate

   bsa_pkg::bsa_mode_e   mode;
   logic [OFF_W-1:0]     off;
   logic [LANES-1:0]     be_d;
   logic [DATA_W-1:0]    data_d;
   logic [ADDR_W-1:0]    word_addr;
   logic                 any_lane;

   assign mode      = bsa_pkg::bsa_mode_e'(req_mode);
   assign off       = req_addr[OFF_W-1:0];
   assign word_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign any_lane  = |be_d;

   bsa_lane_mask #(.LANES(LANES), .OFF_W(OFF_W)) mask_i (
      .off  (off),
      .mode (mode),
      .be   (be_d)
   );

   bsa_lane_gate #(.LANES(LANES), .ZERO_UNUSED(ZERO_UNUSED)) gate_i (
      .din  (req_data),
      .be   (be_d),
      .dout (data_d)
   );

   bsa_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) stage_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (req_valid),
      .go_write    (any_lane),
      .go_probe    (!any_lane),
      .addr_d      (word_addr),
      .be_d        (be_d),
      .data_d      (data_d),
      .wr_valid    (wr_valid),
      .probe_valid (probe_valid),
      .addr_q      (wr_addr),
      .be_q        (wr_be),
      .data_q      (wr_data)
   );

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!wr_valid && !probe_valid));

   assert_head_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_mode) |=> wr_valid);

   assert_tail_aligned_probe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode && req_addr[OFF_W-1:0] == '0) |=> (probe_valid && !wr_valid));

   assert_probe_no_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid |-> (wr_be == '0));

   assert_word_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (wr_addr[ADDR_W-1:OFF_W] == $past(req_addr[ADDR_W-1:OFF_W])));

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && probe_valid));

   assert_write_has_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_be != '0));
endmodule

// File: tb/bytestore_align_tb_top.sv
module bytestore_align_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_mode = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_data = '0;
   logic        wr_valid;
   logic [31:0] wr_addr;
   logic [3:0]  wr_be;
   logic [31:0] wr_data;
   logic        probe_valid;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bytestore_align dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_addr(req_addr), .req_data(req_data), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .probe_valid(probe_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at negedge, check results at the following negedge
   task automatic issue(input logic mode, input logic [31:0] addr, input logic [31:0] data);
      int          off;
      logic [3:0]  ebe;
      logic [31:0] edata;
      string       tag;
      off   = int'(addr[1:0]);
      ebe   = '0;
      edata = '0;
      for (int j = 0; j < 4; j++) begin
         bit on;
         on = (mode == 1'b0) ? (j >= off) : (j < off);
         if (on) begin
            ebe[3-j] = 1'b1;
            edata[31-8*j -: 8] = data[31-8*j -: 8];
         end
      end
      req_valid = 1'b1;
      req_mode  = mode;
      req_addr  = addr;
      req_data  = data;
      @(posedge clk);
      @(negedge clk);
      if (mode == 1'b0) tag = "R3 be";
      else if (off == 0) tag = "R5 be";
      else tag = "R4 be";
      chk(tag, {28'h0, wr_be}, {28'h0, ebe});
      chk("R7 R9 data", wr_data, edata);
      chk("R6 addr", wr_addr, addr & ~32'h3);
      chk("R8 R9 write strobe", {31'h0, wr_valid}, {31'h0, (ebe != 4'h0)});
      chk("R5 R8 probe strobe", {31'h0, probe_valid}, {31'h0, (ebe == 4'h0)});
   endtask

   initial begin
      logic [31:0] pats [6];
      pats[0] = 32'h11223344; pats[1] = 32'hA5C3F00F; pats[2] = 32'hFFFFFFFF;
      pats[3] = 32'h80000001; pats[4] = 32'h0F1E2D3C; pats[5] = 32'hDEADBEEF;
      repeat (3) @(negedge clk);
      chk("R1 write strobe in reset", {31'h0, wr_valid}, 32'h0);
      chk("R1 probe strobe in reset", {31'h0, probe_valid}, 32'h0);
      chk("R1 be in reset", {28'h0, wr_be}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 write strobe after reset", {31'h0, wr_valid}, 32'h0);
      chk("R1 probe strobe after reset", {31'h0, probe_valid}, 32'h0);
      chk("R1 be after reset", {28'h0, wr_be}, 32'h0);

      // back-to-back sweep over every direction, offset and pattern
      for (int p = 0; p < 6; p++) begin
         for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 4; o++) begin
               logic [31:0] a;
               a = {pats[(p + 1) % 6][31:2] ^ 30'(p * 97 + m * 13), 2'(o)};
               issue(m[0], a, pats[p]);
            end
         end
      end
      // probe followed directly by a full write and vice versa
      issue(1'b1, 32'h0000_1000, 32'h12345678);
      issue(1'b0, 32'h0000_2000, 32'hCAFEF00D);
      issue(1'b1, 32'hFFFF_FFFC, 32'h00000000);

      req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R2 idle write strobe", {31'h0, wr_valid}, 32'h0);
      chk("R2 idle probe strobe", {31'h0, probe_valid}, 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule